// File: doc/BRIEF.md
# Multithreaded Issue Slot Allocator

This block sits at the front of a wide issue stage that is shared by several hardware thread contexts. In every cycle each thread reports how many instructions it has ready and whether it is stalled. The block then decides which thread fills each of the eight issue slots. It produces an ordered list of slot owners and, for each thread, the number of slots it was granted.

A three-bit mode input selects the filling policy. In the vertical-only policy a single thread owns the whole width for the cycle. In the other policies, threads share the width within one cycle, either without any limit per thread or with a limit of one, two or four slots per thread. Threads are considered in round-robin order from a rotating pointer, and stalled threads are passed over. The grants are registered, and they appear one cycle after the requests that produced them.

Top module: `issue_slot_alloc`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every slot is idle (slot_valid all zero, slot_tid zero), every grant count is zero and rr_ptr is zero.
- R2: Filled slots form a contiguous run starting at slot 0. Threads are taken in order rr_ptr, rr_ptr+1, … modulo 8, and each thread's slots are adjacent. Slot s carries its thread id in slot_tid[3s+2:3s], and idle slots carry id 0.
- R3: A thread never receives more slots than its ready count (rdy_cnt[4t+3:4t]). A stalled thread (stall_in[t]=1) receives nothing, and so does a thread with a ready count of 0.
- R4: With mode 0 (vertical-only), only the first eligible thread from the pointer issues, and it may take up to all 8 slots.
- R5: With mode 1, or any of the unused codes 5 to 7, threads compete for every slot with no per-thread limit.
- R6: Modes 2, 3 and 4 limit each thread to 1, 2 and 4 slots per cycle respectively.
- R7: With mode 3, four eligible threads that each have at least 2 ready fill all 8 slots.
- R8: rr_ptr advances by one, modulo 8, after every cycle in which at least one slot was granted. It holds its value when nothing was granted, and in that case all slots are idle.
- R9: The outputs are registered. They reflect the requests, including the mode, sampled at the previous clock edge, and they do not change between edges.
- R10: grant_cnt[4t+3:4t] equals the number of valid slots that carry thread id t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Policy: 0 vertical-only, 1 unlimited, 2/3/4 limit 1/2/4, 5–7 unlimited |
| rdy_cnt | input | 32 | Ready instruction count per thread, 4 bits each |
| stall_in | input | 8 | Per-thread stall flag |
| slot_tid | output | 24 | Thread id per slot, 3 bits each |
| slot_valid | output | 8 | Slot is filled |
| grant_cnt | output | 32 | Slots granted per thread, 4 bits each |
| rr_ptr | output | 3 | Current round-robin start thread |

## Verification
A corrupted pointer register shows up in the very next grant cycle. In that cycle slot 0 names the wrong thread, and rr_ptr itself disagrees with the bench's own count of granting cycles. A fault in the fill bookkeeping appears on the cycle it happens, for example a used-slot count that drifts or a limit that is applied wrongly. It shows as a gap in slot_valid, an id that repeats out of order, or a grant count that does not match the slots. Random requests are checked every cycle against a reference fill, so any such error is reported within one cycle of the edge that caused it.

// File: rtl/issue_slot_alloc.sv
module issue_slot_alloc #(
  parameter int NTHR  = 8,
  parameter int NSLOT = 8,
  parameter int CW    = 4,
  localparam int TW = $clog2(NTHR),
  localparam int GW = $clog2(NSLOT + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          mode,
  input  logic [NTHR*CW-1:0]  rdy_cnt,
  input  logic [NTHR-1:0]     stall_in,
  output logic [NSLOT*TW-1:0] slot_tid,
  output logic [NSLOT-1:0]    slot_valid,
  output logic [NTHR*GW-1:0]  grant_cnt,
  output logic [TW-1:0]       rr_ptr
);

  localparam logic [2:0] M_FINE = 3'd0;
  localparam logic [2:0] M_CAP1 = 3'd2;
  localparam logic [2:0] M_CAP2 = 3'd3;
  localparam logic [2:0] M_CAP4 = 3'd4;

  logic [NSLOT*TW-1:0] tid_d;
  logic [NSLOT-1:0]    vld_d;
  logic [NTHR*GW-1:0]  gnt_d;
  int                  cap;

  always_comb begin
    case (mode)
      M_CAP1:  cap = 1;
      M_CAP2:  cap = 2;
      M_CAP4:  cap = 4;
      default: cap = NSLOT;
    endcase
  end

  always_comb begin
    int  used;
    int  give;
    int  t;
    bit  taken;
    used  = 0;
    taken = 1'b0;
    tid_d = '0;
    vld_d = '0;
    gnt_d = '0;
    for (int k = 0; k < NTHR; k++) begin
      t    = (int'(rr_ptr) + k) % NTHR;
      give = int'(rdy_cnt[t*CW +: CW]);
      if (stall_in[t] || (mode == M_FINE && taken)) give = 0;
      if (give > cap) give = cap;
      if (give > NSLOT - used) give = NSLOT - used;
      if (give > 0) taken = 1'b1;
      gnt_d[t*GW +: GW] = GW'(give);
      for (int j = 0; j < NSLOT; j++) begin
        if (j >= used && j < used + give) begin
          vld_d[j]          = 1'b1;
          tid_d[j*TW +: TW] = TW'(t);
        end
      end
      used = used + give;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_tid   <= '0;
      slot_valid <= '0;
      grant_cnt  <= '0;
      rr_ptr     <= '0;
    end else begin
      slot_tid   <= tid_d;
      slot_valid <= vld_d;
      grant_cnt  <= gnt_d;
      if (vld_d[0]) rr_ptr <= TW'((int'(rr_ptr) + 1) % NTHR);
    end
  end

  int              gsum;
  logic [NTHR-1:0] gnz;
  always_comb begin
    gsum = 0;
    for (int t = 0; t < NTHR; t++) begin
      gsum   = gsum + int'(grant_cnt[t*GW +: GW]);
      gnz[t] = (grant_cnt[t*GW +: GW] != '0);
    end
  end

  assert_prefix_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_valid & (slot_valid + 1'b1)) == '0));

  assert_grant_matches_slots_R10: assert property (@(posedge clk) disable iff (!rst_n)
    gsum == $countones(slot_valid));

  assert_single_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == M_FINE) |-> $countones(gnz) <= 1);

  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_valid[0] |-> rr_ptr == $past(rr_ptr));

  assert_ptr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid[0] |-> rr_ptr == TW'((int'($past(rr_ptr)) + 1) % NTHR));

  for (genvar g = 0; g < NTHR; g++) begin : g_cap_chk
    assert_cap_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode) == M_CAP1 |-> grant_cnt[g*GW +: GW] <= 1) and
      ($past(mode) == M_CAP2 |-> grant_cnt[g*GW +: GW] <= 2) and
      ($past(mode) == M_CAP4 |-> grant_cnt[g*GW +: GW] <= 4));
  end

endmodule

// File: tb/issue_slot_alloc_test.sv
`timescale 1ns/1ps
module issue_slot_alloc_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  mode;
  logic [31:0] rdy_cnt;
  logic [7:0]  stall_in;
  logic [23:0] slot_tid;
  logic [7:0]  slot_valid;
  logic [31:0] grant_cnt;
  logic [2:0]  rr_ptr;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [2:0]  mptr;
  logic [23:0] e_tid;
  logic [7:0]  e_vld;
  logic [31:0] e_gnt;

  always #2.5 clk = ~clk;

  issue_slot_alloc uut (.clk(clk), .rst_n(rst_n), .mode(mode), .rdy_cnt(rdy_cnt),
    .stall_in(stall_in), .slot_tid(slot_tid), .slot_valid(slot_valid),
    .grant_cnt(grant_cnt), .rr_ptr(rr_ptr));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [2:0] m, input logic [31:0] r, input logic [7:0] s,
                       input logic [2:0] p, output logic [23:0] tid,
                       output logic [7:0] vld, output logic [31:0] g);
    int fill = 0;
    int lim;
    bit taken = 0;
    lim = (m == 3'd2) ? 1 : (m == 3'd3) ? 2 : (m == 3'd4) ? 4 : 8;
    tid = '0; vld = '0; g = '0;
    for (int k = 0; k < 8; k++) begin
      int t = (int'(p) + k) % 8;
      int n = int'(r[t*4 +: 4]);
      if (s[t] || (m == 3'd0 && taken)) n = 0;
      if (n > lim) n = lim;
      if (n > 8 - fill) n = 8 - fill;
      if (n > 0) taken = 1;
      g[t*4 +: 4] = n[3:0];
      for (int q = 0; q < n; q++) begin
        vld[fill] = 1'b1;
        tid[fill*3 +: 3] = t[2:0];
        fill++;
      end
    end
  endtask

  task automatic step(input logic [2:0] m, input logic [31:0] r, input logic [7:0] s, input string tag);
    logic [7:0] prev_vld;
    prev_vld = e_vld;
    mode = m; rdy_cnt = r; stall_in = s;
    #1;
    chk(slot_valid == prev_vld, "R9 outputs held between edges", {24'd0, slot_valid}, {24'd0, prev_vld});
    model(m, r, s, mptr, e_tid, e_vld, e_gnt);
    @(negedge clk);
    chk(slot_valid == e_vld, {tag, " R2 slot_valid"}, {24'd0, slot_valid}, {24'd0, e_vld});
    chk(slot_tid == e_tid, {tag, " R2 slot_tid"}, {8'd0, slot_tid}, {8'd0, e_tid});
    chk(grant_cnt == e_gnt, {tag, " R10 grant_cnt"}, grant_cnt, e_gnt);
    if (e_vld[0]) mptr = mptr + 3'd1;
    chk(rr_ptr == mptr, {tag, " R8 rr_ptr"}, {29'd0, rr_ptr}, {29'd0, mptr});
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; mode = '0; rdy_cnt = 32'hFFFF_FFFF; stall_in = '0;
    mptr = '0; e_vld = '0; e_tid = '0; e_gnt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(slot_valid == 8'd0 && slot_tid == 24'd0, "R1 reset slots", {24'd0, slot_valid}, 32'd0);
    chk(grant_cnt == 32'd0, "R1 reset grants", grant_cnt, 32'd0);
    chk(rr_ptr == 3'd0, "R1 reset pointer", {29'd0, rr_ptr}, 32'd0);
    rst_n = 1'b1;
    step(3'd0, 32'h3333_3333, 8'h00, "R4 fine one thread");
    step(3'd0, 32'h8888_8888, 8'h02, "R3 R4 stalled skip");
    step(3'd0, 32'h0000_0000, 8'h00, "R3 nothing ready");
    step(3'd1, 32'h1111_1119, 8'h00, "R5 full one big thread");
    step(3'd1, 32'h0000_9000, 8'h00, "R5 full from pointer");
    step(3'd6, 32'h2222_2222, 8'h00, "R5 unused code as full");
    step(3'd3, 32'h0000_5555, 8'h00, "R7 cap2 four threads");
    step(3'd2, 32'hFFFF_FFFF, 8'h00, "R6 cap1");
    step(3'd4, 32'h1F1F_1F1F, 8'h00, "R6 cap4");
    step(3'd1, 32'hFFFF_FFFF, 8'hFF, "R8 all stalled hold");
    step(3'd3, 32'h0101_0101, 8'h10, "R3 small ready counts");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      logic [7:0]  s;
      for (int t = 0; t < 8; t++) r[t*4 +: 4] = 4'($urandom_range(0, 10));
      s = 8'($urandom) & 8'($urandom);
      step(3'($urandom_range(0, 7)), r, s, "R3 R5 R6 random");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule